// File: doc/BRIEF.md
# I2S Sample Halfword Packer

This block sits between a 16-bit register or DMA access port and the serial shifter of an I2S-style audio interface. On the transmit side it collects one or two halfword writes per channel. It places them in a 32-bit slot word with the hardware zero padding that the selected format calls for, and hands that word to the shifter. On the receive side it takes a complete slot word from the shifter and returns it as one or two halfword reads. Any padding position comes back as zero, whatever was on the line.

The format comes from three static configuration inputs: the justification standard, the sample length and the channel length. A combinational access count tells a DMA engine how many halfword transfers each channel takes. The count is 1 for 16-bit samples and 2 for 24- and 32-bit samples. Within a two-access channel the most significant halfword always moves first, and an internal phase bit tracks which halfword comes next. The slot word is left-justified: bit 31 is shifted first, and a 16-bit channel uses bits 31:16 only. The configuration may change only while both directions are idle.

Top module: `hwpk_packer`

## Requirements
- R1: `chan_accesses` is 1 when `cfg_dlen` = 0 (16-bit samples) and 2 when `cfg_dlen` is 1 (24-bit) or 2/3 (32-bit). Encodings: `cfg_std` 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM; `cfg_clen` 0 = 16-bit channel, 1 = 32-bit channel.
- R2: With 16-bit samples in a 16-bit channel, under any standard, the transmit slot is {hw, 16'h0}. The receive read returns slot[31:16].
- R3: With 16-bit samples in a 32-bit channel under Philips, MSB-justified or PCM, the transmit slot is {hw, 16'h0}. The receive read returns slot[31:16], and slot[15:0] is ignored.
- R4: With 16-bit samples in a 32-bit channel under LSB-justified, the transmit slot is {16'h0, hw}. The receive read returns slot[15:0], and slot[31:16] is ignored.
- R5: With 24-bit samples under any standard except LSB-justified, the transmit slot is {hw0, hw1[15:8], 8'h0}, and the low byte of hw1 is ignored. The receive reads are slot[31:16], then {slot[15:8], 8'h0}.
- R6: With 24-bit samples under LSB-justified, the transmit slot is {8'h0, hw0[7:0], hw1}, and the high byte of hw0 is ignored. The receive reads are {8'h0, slot[23:16]}, then slot[15:0].
- R7: With 32-bit samples under any standard, the transmit slot is {hw0, hw1}. The receive reads are slot[31:16], then slot[15:0].
- R8: `tx_slot_valid` rises in the cycle after the channel's last halfword is accepted. `tx_hw_ready` stays low while a slot is pending. The slot word holds steady until it is taken with `tx_slot_ready`.
- R9: `rx_hw_valid` rises in the cycle after a slot is accepted, and the most significant halfword comes first. Each halfword holds steady until `rx_hw_ready`. `rx_slot_ready` stays low until the channel's last halfword has been read.
- R10: After reset, `tx_hw_ready` and `rx_slot_ready` are high, and `tx_slot_valid` and `rx_hw_valid` are low.
- R11: A 24- or 32-bit sample always uses a 32-bit slot, even when `cfg_clen` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_std | input | 2 | Justification standard |
| cfg_dlen | input | 2 | Sample length code |
| cfg_clen | input | 1 | Channel length code |
| chan_accesses | output | 2 | Halfword accesses per channel (1 or 2) |
| tx_hw_valid | input | 1 | Transmit halfword offered by the bus |
| tx_hw_data | input | 16 | Transmit halfword |
| tx_hw_ready | output | 1 | Transmit halfword accepted |
| tx_slot_valid | output | 1 | Assembled slot word available |
| tx_slot_data | output | 32 | Assembled slot word, MSB shifted first |
| tx_slot_ready | input | 1 | Shifter takes the slot word |
| rx_slot_valid | input | 1 | Received slot word from the shifter |
| rx_slot_data | input | 32 | Received slot word, MSB received first |
| rx_slot_ready | output | 1 | Received slot word accepted |
| rx_hw_valid | output | 1 | Receive halfword available |
| rx_hw_data | output | 16 | Receive halfword, padding zeroed |
| rx_hw_ready | input | 1 | Bus reads the halfword |

## Verification
The hardest situation to reach is a padded position that holds non-zero data, because it shows whether the block really discards it. In normal traffic those bits are zero anyway. The stimulus therefore drives full-width pseudo-random slot words into the receiver and pseudo-random halfwords into the transmitter for each of the 32 configuration codes. The second halfword of a two-access channel is also held back by withholding ready for an extra cycle, so the bench sees the phase bit mid-channel.

// File: rtl/hwpk_pkg.sv
package hwpk_pkg;

   typedef enum logic [1:0] {
      STD_PHILIPS = 2'd0,
      STD_MSBJ    = 2'd1,
      STD_LSBJ    = 2'd2,
      STD_PCM     = 2'd3
   } std_e;

   typedef enum logic [1:0] {
      DL_16  = 2'd0,
      DL_24  = 2'd1,
      DL_32A = 2'd2,
      DL_32B = 2'd3
   } dlen_e;

   // Decoded format shared by both directions
   typedef struct packed {
      logic wide_slot;   // slot uses both halves
      logic right_just;  // sample justified to the slot's last bit
      logic len24;       // 24-bit sample
      logic split;       // two halfword accesses per channel
   } fmt_t;

endpackage

// File: rtl/hwpk_fmt.sv
module hwpk_fmt
   import hwpk_pkg::*;
(
   input  logic [1:0] std_i,
   input  logic [1:0] dlen_i,
   input  logic       clen_i,
   output fmt_t       fmt_o,
   output logic [1:0] acc_cnt_o
);

   logic long_sample;

   always_comb begin
      long_sample         = (dlen_e'(dlen_i) != DL_16);
      fmt_o.split         = long_sample;
      fmt_o.len24         = (dlen_e'(dlen_i) == DL_24);
      fmt_o.right_just    = (std_e'(std_i) == STD_LSBJ);
      // longer samples never fit a short slot (R11)
      fmt_o.wide_slot     = long_sample | clen_i;
      acc_cnt_o           = long_sample ? 2'd2 : 2'd1;
   end

endmodule

// File: rtl/hwpk_tx.sv
module hwpk_tx
   import hwpk_pkg::*;
#(
   parameter int HW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_t              fmt,
   input  logic              hw_valid,
   input  logic [HW_W-1:0]   hw_data,
   output logic              hw_ready,
   output logic              slot_valid,
   output logic [2*HW_W-1:0] slot_data,
   input  logic              slot_ready
);

   localparam int SLOT_W = 2 * HW_W;
   localparam int BYTE_W = HW_W / 2;

   logic              phase_q;
   logic [HW_W-1:0]   first_q;
   logic [SLOT_W-1:0] slot_q;
   logic              vld_q;
   logic [SLOT_W-1:0] packed_w;
   logic              accept;

   assign hw_ready   = !vld_q;
   assign accept     = hw_valid && hw_ready;
   assign slot_valid = vld_q;
   assign slot_data  = slot_q;

   always_comb begin
      if (fmt.split) begin
         if (!fmt.len24)
            packed_w = {first_q, hw_data};
         else if (fmt.right_just)
            packed_w = {{BYTE_W{1'b0}}, first_q[BYTE_W-1:0], hw_data};
         else
            packed_w = {first_q, hw_data[HW_W-1:BYTE_W], {BYTE_W{1'b0}}};
      end else if (fmt.wide_slot && fmt.right_just) begin
         packed_w = {{HW_W{1'b0}}, hw_data};
      end else begin
         packed_w = {hw_data, {HW_W{1'b0}}};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         first_q <= '0;
         slot_q  <= '0;
         vld_q   <= 1'b0;
      end else begin
         if (vld_q && slot_ready)
            vld_q <= 1'b0;
         if (accept) begin
            if (fmt.split && !phase_q) begin
               first_q <= hw_data;
               phase_q <= 1'b1;
            end else begin
               slot_q  <= packed_w;
               vld_q   <= 1'b1;
               phase_q <= 1'b0;
            end
         end
      end
   end

   // R8: a pending slot stays put until it is taken
   p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && !slot_ready |=> vld_q && $stable(slot_q));

   // R1: single-access formats never leave a half-built channel
   p_tx_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !fmt.split |-> !phase_q);

   // R4: right-justified 16-bit sample keeps the first half zero
   p_tx_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && !fmt.split && fmt.wide_slot && fmt.right_just
         |-> slot_q[SLOT_W-1:HW_W] == '0);

endmodule

// File: rtl/hwpk_rx.sv
module hwpk_rx
   import hwpk_pkg::*;
#(
   parameter int HW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fmt_t              fmt,
   input  logic              slot_valid,
   input  logic [2*HW_W-1:0] slot_data,
   output logic              slot_ready,
   output logic              hw_valid,
   output logic [HW_W-1:0]   hw_data,
   input  logic              hw_ready
);

   localparam int SLOT_W = 2 * HW_W;
   localparam int BYTE_W = HW_W / 2;

   logic [SLOT_W-1:0] slot_q;
   logic              phase_q;
   logic              vld_q;

   assign slot_ready = !vld_q;
   assign hw_valid   = vld_q;

   always_comb begin
      if (fmt.split) begin
         if (!phase_q)
            hw_data = (fmt.len24 && fmt.right_just)
                      ? {{BYTE_W{1'b0}}, slot_q[HW_W+BYTE_W-1:HW_W]}
                      : slot_q[SLOT_W-1:HW_W];
         else
            hw_data = (fmt.len24 && !fmt.right_just)
                      ? {slot_q[HW_W-1:BYTE_W], {BYTE_W{1'b0}}}
                      : slot_q[HW_W-1:0];
      end else if (fmt.wide_slot && fmt.right_just) begin
         hw_data = slot_q[HW_W-1:0];
      end else begin
         hw_data = slot_q[SLOT_W-1:HW_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q  <= '0;
         phase_q <= 1'b0;
         vld_q   <= 1'b0;
      end else if (slot_valid && !vld_q) begin
         slot_q  <= slot_data;
         phase_q <= 1'b0;
         vld_q   <= 1'b1;
      end else if (vld_q && hw_ready) begin
         if (fmt.split && !phase_q) begin
            phase_q <= 1'b1;
         end else begin
            phase_q <= 1'b0;
            vld_q   <= 1'b0;
         end
      end
   end

   // R9: an unread halfword is held
   p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && !hw_ready |=> vld_q && $stable(hw_data));

   // R9: reading the upper half of a split channel leaves the lower half pending
   p_rx_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && hw_ready && fmt.split && !phase_q |=> vld_q && phase_q);

   // R5: trailing byte of a left-justified 24-bit sample reads as zero
   p_rx_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && phase_q && fmt.len24 && !fmt.right_just
         |-> hw_data[BYTE_W-1:0] == '0);

   // R6: leading byte of a right-justified 24-bit sample reads as zero
   p_rx_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q && !phase_q && fmt.split && fmt.len24 && fmt.right_just
         |-> hw_data[HW_W-1:BYTE_W] == '0);

endmodule

// File: rtl/hwpk_packer.sv
module hwpk_packer
   import hwpk_pkg::*;
#(
   parameter int HW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_std,
   input  logic [1:0]        cfg_dlen,
   input  logic              cfg_clen,
   output logic [1:0]        chan_accesses,
   input  logic              tx_hw_valid,
   input  logic [HW_W-1:0]   tx_hw_data,
   output logic              tx_hw_ready,
   output logic              tx_slot_valid,
   output logic [2*HW_W-1:0] tx_slot_data,
   input  logic              tx_slot_ready,
   input  logic              rx_slot_valid,
   input  logic [2*HW_W-1:0] rx_slot_data,
   output logic              rx_slot_ready,
   output logic              rx_hw_valid,
   output logic [HW_W-1:0]   rx_hw_data,
   input  logic              rx_hw_ready
);

   generate
      if (HW_W < 4 || (HW_W % 2) != 0) begin : g_bad_width
         $error("hwpk_packer: HW_W must be even and at least 4");
      end
   endgenerate

   fmt_t fmt;

   hwpk_fmt u_fmt (
      .std_i     (cfg_std),
      .dlen_i    (cfg_dlen),
      .clen_i    (cfg_clen),
      .fmt_o     (fmt),
      .acc_cnt_o (chan_accesses)
   );

   hwpk_tx #(.HW_W(HW_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt),
      .hw_valid   (tx_hw_valid),
      .hw_data    (tx_hw_data),
      .hw_ready   (tx_hw_ready),
      .slot_valid (tx_slot_valid),
      .slot_data  (tx_slot_data),
      .slot_ready (tx_slot_ready)
   );

   hwpk_rx #(.HW_W(HW_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt),
      .slot_valid (rx_slot_valid),
      .slot_data  (rx_slot_data),
      .slot_ready (rx_slot_ready),
      .hw_valid   (rx_hw_valid),
      .hw_data    (rx_hw_data),
      .hw_ready   (rx_hw_ready)
   );

   // R11 / R1: any sample longer than a halfword needs two accesses
   p_acc_long_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dlen != 2'd0 |-> chan_accesses == 2'd2);

   // R1: 16-bit samples need one access regardless of channel length
   p_acc_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dlen == 2'd0 |-> chan_accesses == 2'd1);

endmodule

// File: tb/hwpk_packer_bench.sv
`timescale 1ns/1ps
module hwpk_packer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_std = 2'd0;
   logic [1:0]  cfg_dlen = 2'd0;
   logic        cfg_clen = 1'b0;
   logic [1:0]  chan_accesses;
   logic        tx_hw_valid = 1'b0;
   logic [15:0] tx_hw_data = '0;
   logic        tx_hw_ready;
   logic        tx_slot_valid;
   logic [31:0] tx_slot_data;
   logic        tx_slot_ready = 1'b0;
   logic        rx_slot_valid = 1'b0;
   logic [31:0] rx_slot_data = '0;
   logic        rx_slot_ready;
   logic        rx_hw_valid;
   logic [15:0] rx_hw_data;
   logic        rx_hw_ready = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [31:0] lcg = 32'h1357_9BDF;

   always #10 clk = ~clk;

   hwpk_packer u_hwpk_packer (
      .clk(clk), .rst_n(rst_n),
      .cfg_std(cfg_std), .cfg_dlen(cfg_dlen), .cfg_clen(cfg_clen),
      .chan_accesses(chan_accesses),
      .tx_hw_valid(tx_hw_valid), .tx_hw_data(tx_hw_data), .tx_hw_ready(tx_hw_ready),
      .tx_slot_valid(tx_slot_valid), .tx_slot_data(tx_slot_data), .tx_slot_ready(tx_slot_ready),
      .rx_slot_valid(rx_slot_valid), .rx_slot_data(rx_slot_data), .rx_slot_ready(rx_slot_ready),
      .rx_hw_valid(rx_hw_valid), .rx_hw_data(rx_hw_data), .rx_hw_ready(rx_hw_ready)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic next_rand(output logic [31:0] v);
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      v = lcg ^ (lcg >> 13);
   endtask

   function automatic int sample_len(input logic [1:0] dl);
      return (dl == 2'd0) ? 16 : (dl == 2'd1) ? 24 : 32;
   endfunction

   function automatic string fmt_tag(input logic [1:0] st, input logic [1:0] dl, input logic cl);
      int d;
      d = sample_len(dl);
      if (d == 16 && !cl) return "R2";
      if (d == 16) return (st == 2'd2) ? "R4" : "R3";
      if (d == 24) return (st == 2'd2) ? (cl ? "R6" : "R6 R11") : (cl ? "R5" : "R5 R11");
      return cl ? "R7" : "R7 R11";
   endfunction

   function automatic logic [31:0] exp_slot(input logic [1:0] st, input logic [1:0] dl, input logic cl,
                                            input logic [31:0] h0, input logic [31:0] h1);
      int d;
      d = sample_len(dl);
      if (d == 16) return (cl && st == 2'd2) ? h0 : (h0 << 16);
      if (d == 24) return (st == 2'd2) ? (((h0 & 32'hFF) << 16) | h1) : ((h0 << 16) | (h1 & 32'hFF00));
      return (h0 << 16) | h1;
   endfunction

   function automatic logic [31:0] exp_read(input logic [1:0] st, input logic [1:0] dl, input logic cl,
                                            input logic [31:0] s, input int k);
      int d;
      d = sample_len(dl);
      if (d == 16) return (cl && st == 2'd2) ? (s & 32'hFFFF) : (s >> 16);
      if (d == 24) begin
         if (st == 2'd2) return (k == 0) ? ((s >> 16) & 32'hFF) : (s & 32'hFFFF);
         return (k == 0) ? (s >> 16) : (s & 32'hFF00);
      end
      return (k == 0) ? (s >> 16) : (s & 32'hFFFF);
   endfunction

   task automatic send_hw(input logic [15:0] d);
      @(negedge clk);
      tx_hw_valid = 1'b1;
      tx_hw_data  = d;
      while (!tx_hw_ready) @(negedge clk);
      @(posedge clk);
      #1 tx_hw_valid = 1'b0;
   endtask

   task automatic run_tx(input logic [1:0] st, input logic [1:0] dl, input logic cl);
      logic [31:0] r0, r1, exp;
      int n;
      string tag;
      n = (dl == 2'd0) ? 1 : 2;
      tag = fmt_tag(st, dl, cl);
      next_rand(r0);
      next_rand(r1);
      r0 = r0 & 32'hFFFF;
      r1 = r1 & 32'hFFFF;
      exp = exp_slot(st, dl, cl, r0, (n == 2) ? r1 : 32'h0);
      send_hw(r0[15:0]);
      if (n == 2) begin
         @(negedge clk);
         check(!tx_slot_valid, "R8 mid-channel", {31'b0, tx_slot_valid}, 32'h0);
         send_hw(r1[15:0]);
      end
      @(negedge clk);
      check(tx_slot_valid, "R8 valid", {31'b0, tx_slot_valid}, 32'h1);
      check(!tx_hw_ready, "R8 ready low", {31'b0, tx_hw_ready}, 32'h0);
      check(tx_slot_data == exp, tag, tx_slot_data, exp);
      @(negedge clk);
      check(tx_slot_valid && tx_slot_data == exp, "R8 hold", tx_slot_data, exp);
      tx_slot_ready = 1'b1;
      @(posedge clk);
      #1 tx_slot_ready = 1'b0;
      @(negedge clk);
      check(!tx_slot_valid && tx_hw_ready, "R8 drained", {30'b0, tx_slot_valid, tx_hw_ready}, 32'h1);
   endtask

   task automatic run_rx(input logic [1:0] st, input logic [1:0] dl, input logic cl);
      logic [31:0] s, exp;
      int n;
      string tag;
      n = (dl == 2'd0) ? 1 : 2;
      tag = fmt_tag(st, dl, cl);
      next_rand(s);
      @(negedge clk);
      check(rx_slot_ready, "R9 idle ready", {31'b0, rx_slot_ready}, 32'h1);
      rx_slot_valid = 1'b1;
      rx_slot_data  = s;
      @(posedge clk);
      #1 rx_slot_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         exp = exp_read(st, dl, cl, s, k);
         @(negedge clk);
         check(rx_hw_valid, "R9 valid", {31'b0, rx_hw_valid}, 32'h1);
         check({16'h0, rx_hw_data} == exp, tag, {16'h0, rx_hw_data}, exp);
         check(!rx_slot_ready, "R9 busy", {31'b0, rx_slot_ready}, 32'h0);
         if (k == 0) begin
            @(negedge clk);
            check(rx_hw_valid && {16'h0, rx_hw_data} == exp, "R9 hold", {16'h0, rx_hw_data}, exp);
         end
         rx_hw_ready = 1'b1;
         @(posedge clk);
         #1 rx_hw_ready = 1'b0;
      end
      @(negedge clk);
      check(!rx_hw_valid && rx_slot_ready, "R9 drained", {30'b0, rx_hw_valid, rx_slot_ready}, 32'h1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(tx_hw_ready && rx_slot_ready, "R10 readies", {30'b0, tx_hw_ready, rx_slot_ready}, 32'h3);
      check(!tx_slot_valid && !rx_hw_valid, "R10 valids", {30'b0, tx_slot_valid, rx_hw_valid}, 32'h0);
      for (int st = 0; st < 4; st++) begin
         for (int dl = 0; dl < 4; dl++) begin
            for (int cl = 0; cl < 2; cl++) begin
               @(negedge clk);
               cfg_std  = st[1:0];
               cfg_dlen = dl[1:0];
               cfg_clen = cl[0];
               #2;
               check(chan_accesses == ((dl == 0) ? 2'd1 : 2'd2), "R1 count",
                     {30'b0, chan_accesses}, (dl == 0) ? 32'd1 : 32'd2);
               for (int rep = 0; rep < 3; rep++) begin
                  run_tx(st[1:0], dl[1:0], cl[0]);
                  run_rx(st[1:0], dl[1:0], cl[0]);
               end
            end
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule